// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the write controller of a paged non-volatile memory. Every byte the controller accepts in a page load is offered to it as one write event, an address and a data byte. The block compares the events against two fixed command sequences. One is a three-byte prefix that unlocks the current load and turns protection on. The other is a six-byte sequence that turns protection off. It also holds the protection flag.

For every write event the block returns one verdict, registered one cycle later. A byte is stored as data, swallowed as a command byte, or discarded. A discarded byte still lets the programming timer run, but no cell changes. The protection flag changes only at the end of the write cycle in which a sequence finished. That holds even when no data byte followed the sequence.

The controller supplies the byte-load window as a level, `win_open`, and the end of programming as a pulse, `cycle_end`.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset `protect_on` is 0 and `vrd_valid` is 0.
- R2: Each cycle with `wr_valid` high produces exactly one cycle of `vrd_valid` on the next cycle, and `vrd_valid` is never high otherwise. The verdict codes are: `vrd_kind` 2'b00 = store, 2'b01 = swallow (command byte), 2'b10 = discard. The code 2'b11 never appears.
- R3: Command matching uses address bits [14:0] only, with bits [18:15] ignored. It uses all 8 data bits. A byte whose address or data differs in any compared bit is not a command byte.
- R4: The protect sequence is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. All three bytes are swallowed. Later bytes of the same load are stored. `protect_on` goes to 1 on the cycle after `cycle_end`, even if no data byte was loaded.
- R5: The unprotect sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x20 at 0x5555. All six bytes are swallowed and later bytes of the same load are stored. `protect_on` goes to 0 on the cycle after `cycle_end`, even if no data byte followed.
- R6: While protection is on, a byte in a load that has not completed a sequence is discarded.
- R7: `protect_on` changes only on the cycle after a `cycle_end` pulse. It stays set over any number of write cycles until an unprotect sequence completes.
- R8: A byte that breaks a partly matched sequence returns the matcher to idle and is judged as an ordinary byte (stored, or discarded under protection). The bytes already swallowed stay consumed. If the breaking byte is 0xAA at 0x5555, it is swallowed and starts a new sequence.
- R9: If `win_open` is low while a sequence is partly matched, the partial match is dropped. The next byte is then judged from idle.
- R10: Once a sequence has completed in a load, every further byte of that load is treated as data, even if it equals a command byte.
- R11: A write offered in the same cycle as `cycle_end` is judged against the state after that cycle ends: the updated flag and an idle matcher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One accepted byte-write event this cycle |
| wr_addr | input | ADDR_W (19) | Byte address of the event |
| wr_data | input | DATA_W (8) | Data byte of the event |
| win_open | input | 1 | High while the byte-load window is open |
| cycle_end | input | 1 | One-cycle pulse when a write cycle finishes |
| vrd_valid | output | 1 | Verdict valid for the event of the previous cycle |
| vrd_kind | output | 2 | Verdict: 00 store, 01 swallow, 10 discard |
| protect_on | output | 1 | Protection flag |

## Verification
The bench drives a sequence that stops one byte short and then offers a wrong byte. A matcher that never resets would wrongly swallow the later bytes or unlock the load. It sends a restart byte in the middle of a sequence; a design that fails to re-arm would store a byte that should be swallowed. It lets the window lapse between the second and third prefix bytes; a design without the timeout would accept the stale prefix and unlock. It also repeats command bytes after a completed sequence, sets high address bits that matching must ignore, and offers a write in the same cycle as `cycle_end`. A design that judged that last write with the old flag would store it instead of discarding it.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

  typedef enum logic [1:0] {
    VK_STORE   = 2'b00,
    VK_SWALLOW = 2'b01,
    VK_DISCARD = 2'b10
  } verdict_e;

  localparam int SEQ_LEN     = 6;
  localparam int CMD_CMP_W   = 15;
  localparam int UNLOCK_STEP = 2;
  localparam logic [7:0] UNLOCK_DATA = 8'hA0;

  // Address expected at each step of the long (unprotect) sequence
  function automatic logic [CMD_CMP_W-1:0] step_addr(input int k);
    case (k)
      1, 4:    step_addr = 15'h2AAA;
      default: step_addr = 15'h5555;
    endcase
  endfunction

  // Data expected at each step of the long (unprotect) sequence
  function automatic logic [7:0] step_data(input int k);
    case (k)
      0, 3:    step_data = 8'hAA;
      1, 4:    step_data = 8'h55;
      2:       step_data = 8'h80;
      default: step_data = 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/wpd_seq_match.sv
module wpd_seq_match
  import wpd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_open,
  input  logic              cycle_end,
  output logic              cmd_byte,
  output logic              unlock_hit,
  output logic              disable_hit
);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_eff;
  logic               done_q, done_d, done_eff;
  logic [SEQ_LEN-1:0] step_hit;
  logic               unlock_match;
  logic               cur_hit;

  // One comparator per sequence step
  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_step
    assign step_hit[k] = (wr_addr[CMD_CMP_W-1:0] == step_addr(k)) &&
                         (wr_data == DATA_W'(step_data(k)));
  end

  assign unlock_match = (wr_addr[CMD_CMP_W-1:0] == step_addr(UNLOCK_STEP)) &&
                        (wr_data == DATA_W'(UNLOCK_DATA));

  always_comb begin
    cur_hit = 1'b0;
    for (int k = 0; k < SEQ_LEN; k++) begin
      if (cnt_eff == CNT_W'(k)) cur_hit = step_hit[k];
    end
  end

  always_comb begin
    cnt_eff  = (cycle_end || !win_open) ? '0 : cnt_q;
    done_eff = cycle_end ? 1'b0 : done_q;
    cnt_d       = cnt_eff;
    done_d      = done_eff;
    cmd_byte    = 1'b0;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    if (wr_valid && !done_eff) begin
      if ((cnt_eff == CNT_W'(UNLOCK_STEP)) && unlock_match) begin
        cmd_byte   = 1'b1;
        unlock_hit = 1'b1;
        done_d     = 1'b1;
        cnt_d      = '0;
      end else if (cur_hit) begin
        cmd_byte = 1'b1;
        if (cnt_eff == CNT_W'(SEQ_LEN - 1)) begin
          disable_hit = 1'b1;
          done_d      = 1'b1;
          cnt_d       = '0;
        end else begin
          cnt_d = cnt_eff + 1'b1;
        end
      end else if (step_hit[0]) begin
        cmd_byte = 1'b1;
        cnt_d    = CNT_W'(1);
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/wpd_prot_state.sv
module wpd_prot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end,
  input  logic unlock_hit,
  input  logic disable_hit,
  output logic protect_q,
  output logic prot_eff,
  output logic unlocked_eff
);
  logic pset_q, pset_d, pset_eff;
  logic pclr_q, pclr_d, pclr_eff;
  logic unl_q, unl_d;

  always_comb begin
    if (cycle_end) begin
      prot_eff     = pclr_q ? 1'b0 : (pset_q ? 1'b1 : protect_q);
      pset_eff     = 1'b0;
      pclr_eff     = 1'b0;
      unlocked_eff = 1'b0;
    end else begin
      prot_eff     = protect_q;
      pset_eff     = pset_q;
      pclr_eff     = pclr_q;
      unlocked_eff = unl_q;
    end
    pset_d = pset_eff | unlock_hit;
    pclr_d = pclr_eff | disable_hit;
    unl_d  = unlocked_eff | unlock_hit | disable_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect_q <= 1'b0;
      pset_q    <= 1'b0;
      pclr_q    <= 1'b0;
      unl_q     <= 1'b0;
    end else begin
      if (cycle_end) protect_q <= prot_eff;
      pset_q <= pset_d;
      pclr_q <= pclr_d;
      unl_q  <= unl_d;
    end
  end

endmodule

// File: rtl/wpd_verdict.sv
module wpd_verdict
  import wpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       cmd_byte,
  input  logic       prot_eff,
  input  logic       unlocked_eff,
  output logic       vrd_valid,
  output logic [1:0] vrd_kind
);
  verdict_e kind_d;

  always_comb begin
    if (cmd_byte)                      kind_d = VK_SWALLOW;
    else if (prot_eff && !unlocked_eff) kind_d = VK_DISCARD;
    else                                kind_d = VK_STORE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrd_valid <= 1'b0;
      vrd_kind  <= VK_STORE;
    end else begin
      vrd_valid <= wr_valid;
      if (wr_valid) vrd_kind <= kind_d;
    end
  end

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_open,
  input  logic              cycle_end,
  output logic              vrd_valid,
  output logic [1:0]        vrd_kind,
  output logic              protect_on
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       cmd_byte, unlock_hit, disable_hit;
  logic       prot_eff, unlocked_eff;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wpd_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_open(win_open), .cycle_end(cycle_end),
    .cmd_byte(cmd_byte), .unlock_hit(unlock_hit), .disable_hit(disable_hit)
  );

  wpd_prot_state u_prot (
    .clk(clk), .rst_n(rst_sync_n), .cycle_end(cycle_end),
    .unlock_hit(unlock_hit), .disable_hit(disable_hit),
    .protect_q(protect_on), .prot_eff(prot_eff), .unlocked_eff(unlocked_eff)
  );

  wpd_verdict u_vrd (
    .clk(clk), .rst_n(rst_sync_n), .wr_valid(wr_valid), .cmd_byte(cmd_byte),
    .prot_eff(prot_eff), .unlocked_eff(unlocked_eff),
    .vrd_valid(vrd_valid), .vrd_kind(vrd_kind)
  );

endmodule

// File: rtl/wpd_checker.sv
module wpd_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cycle_end,
  input logic              vrd_valid,
  input logic [1:0]        vrd_kind,
  input logic              protect_on
);
  assert_verdict_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> vrd_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !vrd_valid);

  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |-> (vrd_kind != 2'b11));

  assert_prot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> $stable(protect_on));

  assert_discard_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && vrd_kind == 2'b10) |-> protect_on);

  assert_swallow_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && vrd_kind == 2'b01) |->
      ($past(wr_addr[14:0]) == 15'h5555 || $past(wr_addr[14:0]) == 15'h2AAA));

endmodule

bind wp_seq_detect wpd_checker #(.ADDR_W(ADDR_W)) u_wpd_checker (
  .clk(clk), .rst_n(rst_sync_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .cycle_end(cycle_end), .vrd_valid(vrd_valid), .vrd_kind(vrd_kind),
  .protect_on(protect_on)
);

// File: tb/wp_seq_detect_bench.sv
module wp_seq_detect_bench;
  localparam logic [1:0] K_ST = 2'b00, K_SW = 2'b01, K_DI = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, win_open, cycle_end;
  logic [18:0] wr_addr;
  logic [7:0]  wr_data;
  logic        vrd_valid, protect_on;
  logic [1:0]  vrd_kind;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  wp_seq_detect u_wp_seq_detect (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_open(win_open), .cycle_end(cycle_end),
    .vrd_valid(vrd_valid), .vrd_kind(vrd_kind), .protect_on(protect_on)
  );

  // Monitor: pops one expected verdict for each verdict seen
  always @(negedge clk) begin
    if (rst_n && vrd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected verdict %b, expected none", vrd_kind);
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (vrd_kind !== e) begin
          errors++;
          $display("FAIL %s: verdict %b, expected %b", t, vrd_kind, e);
        end
      end
    end
  end

  task automatic wr(input logic [18:0] a, input logic [7:0] d,
                    input logic [1:0] k, input string t);
    exp_q.push_back(k);
    tag_q.push_back(t);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic open_w();
    win_open = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_w();
    win_open = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_cycle();
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0;
  endtask

  task automatic end_cycle_wr(input logic [18:0] a, input logic [7:0] d,
                              input logic [1:0] k, input string t);
    cycle_end = 1'b1;
    wr(a, d, k, t);
    cycle_end = 1'b0;
  endtask

  task automatic chk_prot(input logic e, input string t);
    checks++;
    if (protect_on !== e) begin
      errors++;
      $display("FAIL %s: protect_on %b, expected %b", t, protect_on, e);
    end
  endtask

  task automatic seq_protect(input string t);
    wr(19'h05555, 8'hAA, K_SW, t);
    wr(19'h02AAA, 8'h55, K_SW, t);
    wr(19'h05555, 8'hA0, K_SW, t);
  endtask

  task automatic seq_unprotect(input string t);
    wr(19'h05555, 8'hAA, K_SW, t);
    wr(19'h02AAA, 8'h55, K_SW, t);
    wr(19'h05555, 8'h80, K_SW, t);
    wr(19'h05555, 8'hAA, K_SW, t);
    wr(19'h02AAA, 8'h55, K_SW, t);
    wr(19'h05555, 8'h20, K_SW, t);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; win_open = 1'b0; cycle_end = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_prot(1'b0, "R1");
    checks++;
    if (vrd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: vrd_valid %b, expected 0", vrd_valid);
    end

    // R2 / R3: plain write unprotected; near-miss address
    open_w();
    wr(19'h00123, 8'h5A, K_ST, "R2");
    wr(19'h05556, 8'hAA, K_ST, "R3");
    close_w(); end_cycle();
    chk_prot(1'b0, "R2");

    // R4 without data; R7 flag waits for cycle end
    open_w();
    seq_protect("R4");
    close_w();
    chk_prot(1'b0, "R7");
    end_cycle();
    chk_prot(1'b1, "R4");

    // R6: unprefixed write discarded
    open_w();
    wr(19'h00100, 8'h11, K_DI, "R6");
    close_w(); end_cycle();
    chk_prot(1'b1, "R7");

    // R3 high bits ignored, R4 data stored, R10 command-like data after completion
    open_w();
    wr(19'h45555, 8'hAA, K_SW, "R3");
    wr(19'h7AAAA, 8'h55, K_SW, "R3");
    wr(19'h05555, 8'hA0, K_SW, "R4");
    wr(19'h00200, 8'h33, K_ST, "R4");
    wr(19'h05555, 8'hAA, K_ST, "R10");
    wr(19'h02AAA, 8'h55, K_ST, "R10");
    close_w(); end_cycle();

    // R8: break with wrong data bit, then stray third byte from idle
    open_w();
    wr(19'h05555, 8'hAA, K_SW, "R8");
    wr(19'h02AAA, 8'h54, K_DI, "R8");
    wr(19'h05555, 8'hA0, K_DI, "R8");
    close_w(); end_cycle();

    // R8: restart byte re-arms the sequence
    open_w();
    wr(19'h05555, 8'hAA, K_SW, "R8");
    wr(19'h05555, 8'hAA, K_SW, "R8");
    wr(19'h02AAA, 8'h55, K_SW, "R8");
    wr(19'h05555, 8'hA0, K_SW, "R8");
    wr(19'h00300, 8'h77, K_ST, "R8");
    close_w(); end_cycle();

    // R9: window lapse drops the partial prefix
    open_w();
    wr(19'h05555, 8'hAA, K_SW, "R9");
    wr(19'h02AAA, 8'h55, K_SW, "R9");
    close_w(); close_w();
    open_w();
    wr(19'h05555, 8'hA0, K_DI, "R9");
    close_w(); end_cycle();
    chk_prot(1'b1, "R9");

    // R5: unprotect with data
    open_w();
    seq_unprotect("R5");
    wr(19'h00010, 8'h44, K_ST, "R5");
    close_w();
    chk_prot(1'b1, "R7");
    end_cycle();
    chk_prot(1'b0, "R5");

    open_w();
    wr(19'h00020, 8'h99, K_ST, "R5");
    close_w(); end_cycle();

    // R11: write in the cycle that ends the protect cycle
    open_w();
    seq_protect("R4");
    close_w();
    end_cycle_wr(19'h00040, 8'h12, K_DI, "R11");
    chk_prot(1'b1, "R11");

    // R5: unprotect without data
    open_w();
    seq_unprotect("R5");
    close_w(); end_cycle();
    chk_prot(1'b0, "R5");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d verdicts missing, expected 0", exp_q.size());
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule